// File: doc/BRIEF.md
# Three-Phase Triangular-Modulation PWM Generator

This block drives the six gate signals of a three-phase inverter bridge. A carrier down-counter reloads from a programmable period each time it reaches zero. Each zero event starts a one-shot count in each of the three phase timers (U, V and W). Each phase keeps two reload values, a first and a second. It loads them on alternate carrier periods, so the edges of a phase can sit anywhere within a triangular carrier cycle.

A single polarity-seed bit is copied into every phase's polarity flip-flop at each zero event, and then the seed inverts itself. When a phase's one-shot expires, that phase's flip-flop inverts. Each change of a flip-flop starts a dead-time count. For the length of that count, both the true output and the complementary output of the phase stay inactive. An interrupt pulse can mark every second or every fourth carrier zero, and a select bit chooses whether it marks the zeros where the seed was 0 or the zeros where it was 1.

Software programs the reload values through one write port. A per-phase route bit decides whether a write goes to the first or the second reload value.

Top module: `pwm3_tri`

## Requirements
- R1: After reset, all polarity flip-flops, the seed, the route bits, the alternation state, the reload values and the interrupt divider are 0. `pwm_t` reads 3'b111, `pwm_c` reads 3'b000 and `irq` reads 0. While `en` is low the carrier counter holds its value and no zero event occurs.
- R2: With `en` high, a zero event occurs on every clock edge at which the carrier counter is 0. The counter is 0 after reset, so the first zero event is the first enabled edge. After a zero event the counter loads `period` and counts down by one per cycle, which gives one zero event every `period`+1 cycles.
- R3: On each zero event every phase loads its one-shot counter from the first reload value and the second reload value in turn. The first zero event after reset uses the first value.
- R4: A write with `wr_en` high and `wr_phase` equal to 0, 1 or 2 (U, V, W) stores `wr_data` into that phase's second reload value when route bit `sel[phase]` is 1, and into its first reload value when the bit is 0. A write with `wr_phase`=3 changes nothing. `sel_we` loads the three route bits from `sel_d`.
- R5: At each zero event every phase flip-flop takes the seed value, and the seed then inverts. A `buf_we` at the same edge loads `buf_d` into the seed, and this load takes precedence over the inversion.
- R6: A phase flip-flop inverts N cycles after a zero event that loaded the reload value N≥1. A loaded value of 0 gives no inversion in that period. A zero event that arrives before the count completes restarts the count.
- R7: Every change of a phase flip-flop holds both `pwm_t` and `pwm_c` of that phase at 1 for `dead` cycles. Outside that window, `pwm_t`=~ff and `pwm_c`=ff (low is active). The two outputs of a phase are never both 0.
- R8: A zero event counts toward the interrupt only if the seed held before that zero equals `irq_on_one`.
- R9: `irq` is a one-cycle pulse in the cycle after a qualifying zero event. It fires on every qualifying zero when `irq_every4`=0 and on every second qualifying zero when `irq_every4`=1, starting with the second one after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Carrier run enable |
| period | input | CW | Carrier reload value |
| dead | input | DW | Dead-time length in cycles |
| wr_en | input | 1 | Reload write strobe |
| wr_phase | input | 2 | Target phase (0 U, 1 V, 2 W, 3 none) |
| wr_data | input | CW | Reload write data |
| sel_we | input | 1 | Route-bit write strobe |
| sel_d | input | 3 | Route bits, one per phase |
| buf_we | input | 1 | Seed write strobe |
| buf_d | input | 1 | Seed write value |
| irq_every4 | input | 1 | 0: every qualifying zero, 1: every second one |
| irq_on_one | input | 1 | Seed value that qualifies a zero |
| pwm_t | output | 3 | True phase outputs, active low |
| pwm_c | output | 3 | Complementary phase outputs, active low |
| irq | output | 1 | Interrupt pulse |

## Verification
Every register in the block updates at the edge that samples its cause, so each result appears one cycle after that edge. The seed copy and a restarted one-shot appear one cycle after the zero edge. A flip-flop inversion appears N cycles after the zero edge. A dead-time window covers the `dead` cycles after the edge that changed the flip-flop. The interrupt pulse lasts exactly the one cycle after its zero edge. The bench advances a behavioural model on the same rising edge as the design and compares the outputs at the falling edge, so every result is sampled in the cycle in which it is due. The stimulus covers a zero reload value, a zero event that restarts a running count, writes to phase 3, seed writes during running, both decimation settings, both qualifying seed values and a zero dead time.

// File: rtl/pwm3_tri.sv
module pwm3_tri #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] period,
  input  logic [DW-1:0] dead,
  input  logic          wr_en,
  input  logic [1:0]    wr_phase,
  input  logic [CW-1:0] wr_data,
  input  logic          sel_we,
  input  logic [2:0]    sel_d,
  input  logic          buf_we,
  input  logic          buf_d,
  input  logic          irq_every4,
  input  logic          irq_on_one,
  output logic [2:0]    pwm_t,
  output logic [2:0]    pwm_c,
  output logic          irq
);
  logic [CW-1:0] cnt;
  logic [2:0]    sel;
  logic          alt, pbuf, icnt;

  wire zero = en && (cnt == '0);
  wire qual = zero && (pbuf == irq_on_one);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      alt  <= 1'b0;
      pbuf <= 1'b0;
      sel  <= '0;
      icnt <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (en) cnt <= zero ? period : cnt - 1'b1;
      if (zero) alt <= ~alt;
      if (buf_we) pbuf <= buf_d;
      else if (zero) pbuf <= ~pbuf;
      if (sel_we) sel <= sel_d;
      irq <= qual && (icnt == irq_every4);
      if (qual) icnt <= irq_every4 ? ~icnt : 1'b0;
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_ph
    logic [CW-1:0] pri, sec, pc;
    logic          run, ff;
    logic [DW-1:0] dt;

    wire [CW-1:0] ld   = alt ? sec : pri;
    wire          done = run && (pc == 1) && !zero;
    wire          nff  = zero ? pbuf : (done ? ~ff : ff);
    wire          hold = (dt != '0);

    assign pwm_t[g] = hold | ~ff;
    assign pwm_c[g] = hold | ff;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pri <= '0;
        sec <= '0;
        pc  <= '0;
        run <= 1'b0;
        ff  <= 1'b0;
        dt  <= '0;
      end else begin
        if (wr_en && wr_phase == 2'(g)) begin
          if (sel[g]) sec <= wr_data;
          else        pri <= wr_data;
        end
        if (zero) begin
          pc  <= ld;
          run <= (ld != '0);
        end else if (done) begin
          run <= 1'b0;
        end else if (run) begin
          pc <= pc - 1'b1;
        end
        ff <= nff;
        if (nff != ff) dt <= dead;
        else if (hold) dt <= dt - 1'b1;
      end
    end
  end
endmodule

module pwm3_tri_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          zero,
  input logic          buf_we,
  input logic          pbuf,
  input logic [CW-1:0] cnt,
  input logic          irq,
  input logic [2:0]    pwm_t,
  input logic [2:0]    pwm_c
);
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pwm_t & ~pwm_c) == 3'b000));
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == $past(cnt)));
  assert_seed_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !buf_we) |=> (pbuf != $past(pbuf)));
  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(zero));
endmodule

bind pwm3_tri pwm3_tri_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .zero(zero), .buf_we(buf_we),
  .pbuf(pbuf), .cnt(cnt), .irq(irq), .pwm_t(pwm_t), .pwm_c(pwm_c)
);

// File: tb/pwm3_tri_bench.sv
module pwm3_tri_bench;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [15:0] period = 16'd19, wr_data = '0;
  logic [7:0]  dead = 8'd2;
  logic wr_en = 0, sel_we = 0, buf_we = 0, buf_d = 0, irq_every4 = 0, irq_on_one = 0;
  logic [1:0] wr_phase = '0;
  logic [2:0] sel_d = '0, pwm_t, pwm_c;
  logic irq;

  int errors = 0, checks = 0;
  bit finished = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  pwm3_tri u_pwm3_tri (.*);

  // behavioural reference
  int m_cnt = 0, m_pri[3] = '{0,0,0}, m_sec[3] = '{0,0,0}, m_pc[3] = '{0,0,0}, m_dt[3] = '{0,0,0};
  bit m_alt = 0, m_buf = 0, m_icnt = 0, m_irq = 0;
  bit m_run[3] = '{0,0,0}, m_ff[3] = '{0,0,0}, m_sel[3] = '{0,0,0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_alt = 0; m_buf = 0; m_icnt = 0; m_irq = 0;
      foreach (m_ff[i]) begin
        m_pri[i] = 0; m_sec[i] = 0; m_pc[i] = 0; m_dt[i] = 0;
        m_run[i] = 0; m_ff[i] = 0; m_sel[i] = 0;
      end
    end else begin
      bit z, q, nff;
      z = en && m_cnt == 0;
      q = z && (m_buf == irq_on_one);
      for (int i = 0; i < 3; i++) begin
        int v;
        v = m_alt ? m_sec[i] : m_pri[i];
        nff = m_ff[i];
        if (z) begin
          m_pc[i] = v; m_run[i] = (v != 0);
        end else if (m_run[i]) begin
          if (m_pc[i] == 1) begin m_run[i] = 0; nff = !m_ff[i]; end
          else m_pc[i] = m_pc[i] - 1;
        end
        if (z) nff = m_buf;
        if (nff != m_ff[i]) m_dt[i] = dead;
        else if (m_dt[i] != 0) m_dt[i] = m_dt[i] - 1;
        m_ff[i] = nff;
      end
      m_irq = q && (m_icnt == irq_every4);
      if (q) m_icnt = irq_every4 ? !m_icnt : 1'b0;
      if (en) m_cnt = z ? int'(period) : m_cnt - 1;
      if (z) m_alt = !m_alt;
      if (buf_we) m_buf = buf_d; else if (z) m_buf = !m_buf;
      if (wr_en && wr_phase != 3) begin
        if (m_sel[wr_phase]) m_sec[wr_phase] = int'(wr_data);
        else m_pri[wr_phase] = int'(wr_data);
      end
      if (sel_we) foreach (m_sel[i]) m_sel[i] = sel_d[i];
    end
  end

  task automatic chk(input string t, input logic [5:0] act, input logic [5:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", t, $time, act, exp_v);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    logic [2:0] et, ec;
    for (int i = 0; i < 3; i++) begin
      et[i] = (m_dt[i] != 0) | !m_ff[i];
      ec[i] = (m_dt[i] != 0) |  m_ff[i];
    end
    chk({tag, " R7 pwm"}, {pwm_t, pwm_c}, {et, ec});
    chk({tag, " R9 irq"}, {5'b0, irq}, {5'b0, m_irq});
  end

  task automatic wr(input logic [1:0] ph, input int d);
    @(negedge clk); wr_en = 1; wr_phase = ph; wr_data = 16'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic setsel(input logic [2:0] s);
    @(negedge clk); sel_we = 1; sel_d = s;
    @(negedge clk); sel_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {pwm_t, pwm_c, irq}, {3'b111, 3'b000, 1'b0});
    rst_n = 1;
    tag = "R1 idle";
    repeat (5) @(negedge clk);
    chk("R1 idle", {pwm_t, pwm_c, irq}, {3'b111, 3'b000, 1'b0});
    // R4 routing: first values with sel=0, second values with sel=1, phase 3 ignored
    tag = "R4";
    wr(0, 5); wr(1, 0); wr(2, 9);
    setsel(3'b111);
    wr(0, 12); wr(1, 7); wr(2, 3);
    wr(3, 1);
    tag = "R3 R6 R8 every2";
    en = 1;
    repeat (200) @(negedge clk);
    tag = "R9 every4";
    irq_every4 = 1;
    repeat (200) @(negedge clk);
    tag = "R8 on_one";
    irq_on_one = 1;
    repeat (200) @(negedge clk);
    tag = "R5 seed write";
    @(negedge clk); buf_we = 1; buf_d = 1;
    @(negedge clk); buf_we = 0;
    repeat (37) @(negedge clk);
    @(negedge clk); buf_we = 1; buf_d = 0;
    @(negedge clk); buf_we = 0;
    repeat (100) @(negedge clk);
    tag = "R7 no dead";
    dead = 0;
    repeat (100) @(negedge clk);
    tag = "R6 restart";
    dead = 3; period = 4;
    wr(2, 11);
    repeat (150) @(negedge clk);
    tag = "R2 short period";
    period = 0;
    repeat (40) @(negedge clk);
    tag = "R1 hold";
    period = 7; en = 0;
    repeat (30) @(negedge clk);
    tag = "R4 rewrite";
    setsel(3'b000);
    wr(0, 2); wr(1, 6);
    en = 1;
    repeat (120) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule